// File: doc/BRIEF.md
# SCL Clock Divider Generator

This block produces the low and high phases of an I2C serial clock from the system clock. A power-of-two prescaler turns the system clock into prescaled ticks. Two programmable counts then set the length of the high phase and the length of the low phase in those ticks. Each count is stored as its length minus one. The bus engine holds the divider on through an enable and a run request. The block answers with a drive-low request for SCL and one-cycle strobes that mark each falling and rising edge.

A combinational helper sits alongside the divider. It turns one requested total divisor into the three timing fields. It picks the smallest prescale exponent for which the divisor fits the phase counters. It splits the scaled total so that the high phase is never shorter than the low phase. A request too large to reach is clamped to the slowest setting. The phase count width defaults to 4 bits, and a parameter selects a 3-bit variant.

Top module: `scl_divgen`

## Requirements
- R1: After the run request rises, with enable high, SCL is released, and the first falling strobe comes after exactly (hi+1)·2^exp system clocks. Every later high phase has the same length.
- R2: Every low phase, from a falling strobe to the next rising strobe, lasts (lo+1)·2^exp system clocks.
- R3: `fall_o` and `rise_o` are each one system clock long. They are never high together. `fall_o` is high in the first cycle in which `scl_low_o` is 1, and `rise_o` is high in the first cycle in which `scl_low_o` is 0 again.
- R4: In the cycle after enable or run goes low, SCL is released and both strobes are low, even in the middle of a low phase. The prescaler and phase counters are cleared, so the next run starts with a full high phase.
- R5: A stored count of zero gives a phase one prescaled tick long. With exp=0 and both counts at zero, SCL toggles on every system clock.
- R6: The helper returns exponent 0 when the divisor is at most the maximum total T. T is 2^(PW+1): 32 for 4-bit counts and 16 for 3-bit counts. Otherwise it returns the smallest exponent e for which divisor ≤ T·2^e.
- R7: When no exponent up to 15 meets R6, the helper returns exponent 15 with both counts all ones.
- R8: Otherwise the helper takes S = ceil(divisor/2^e). The low length is floor(S/2) and the high length is S minus that, so any odd tick goes to the high phase. Each length is stored minus one, with a floor of zero.
- R9: With PW=3 the helper follows R6 to R8 using T=16 and 3-bit counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Divider enable |
| run | input | 1 | Run request from the bus engine |
| exp_i | input | EW | Prescale exponent, prescale = 2^exp_i |
| hi_i | input | PW | High phase length minus one, in prescaled ticks |
| lo_i | input | PW | Low phase length minus one, in prescaled ticks |
| div_req_i | input | DW | Requested total divisor for the helper |
| scl_low_o | output | 1 | Request to drive SCL low |
| rise_o | output | 1 | One-cycle strobe on the SCL rising edge |
| fall_o | output | 1 | One-cycle strobe on the SCL falling edge |
| cfg_exp_o | output | EW | Helper: computed exponent |
| cfg_hi_o | output | PW | Helper: computed high count |
| cfg_lo_o | output | PW | Helper: computed low count |

## Verification
Two actions can fall on the same clock edge. One is a stop request that lands exactly where a phase would wrap. The other is an edge strobe that would be due in that same cycle. The bench drops the run request in the middle of a low phase and also right on a falling edge. It then checks that the cycle after the stop shows SCL released with neither strobe raised. It then checks that the following run begins with a full-length high phase. Randomised exponents and counts also exercise the zero-count case, where the phase wrap and the prescaler wrap happen on every edge.

// File: rtl/scl_divgen.sv
`timescale 1ns/1ps
module scl_divgen #(
  parameter int PW = 4,
  parameter int EW = 4,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          run,
  input  logic [EW-1:0] exp_i,
  input  logic [PW-1:0] hi_i,
  input  logic [PW-1:0] lo_i,
  input  logic [DW-1:0] div_req_i,
  output logic          scl_low_o,
  output logic          rise_o,
  output logic          fall_o,
  output logic [EW-1:0] cfg_exp_o,
  output logic [PW-1:0] cfg_hi_o,
  output logic [PW-1:0] cfg_lo_o
);
  localparam int PSW  = (1 << EW) - 1;
  localparam int EMAX = (1 << EW) - 1;
  localparam int MAXT = 2 << PW;

  logic [PSW-1:0] pre_cnt;
  logic [PW-1:0]  ph_cnt;

  wire            go      = en & run;
  wire [PSW-1:0]  pre_lim = (PSW'(1) << exp_i) - PSW'(1);
  wire            tick    = (pre_cnt == pre_lim);
  wire [PW-1:0]   cur_len = scl_low_o ? lo_i : hi_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt   <= '0;
      ph_cnt    <= '0;
      scl_low_o <= 1'b0;
      rise_o    <= 1'b0;
      fall_o    <= 1'b0;
    end else if (!go) begin
      pre_cnt   <= '0;
      ph_cnt    <= '0;
      scl_low_o <= 1'b0;
      rise_o    <= 1'b0;
      fall_o    <= 1'b0;
    end else begin
      pre_cnt <= tick ? '0 : pre_cnt + PSW'(1);
      rise_o  <= 1'b0;
      fall_o  <= 1'b0;
      if (tick) begin
        if (ph_cnt == cur_len) begin
          ph_cnt    <= '0;
          scl_low_o <= ~scl_low_o;
          fall_o    <= ~scl_low_o;
          rise_o    <= scl_low_o;
        end else begin
          ph_cnt <= ph_cnt + PW'(1);
        end
      end
    end
  end

  logic [DW-1:0] q;
  logic [DW:0]   step, tot;
  int            msb, e, lo_len, hi_len;

  always_comb begin
    q   = (div_req_i - DW'(1)) >> (PW + 1);
    msb = 0;
    for (int i = 0; i < DW; i++) if (q[i]) msb = i;
    e      = (div_req_i > DW'(MAXT)) ? msb + 1 : 0;
    step   = '0;
    tot    = '0;
    lo_len = 0;
    hi_len = 0;
    if (e > EMAX) begin
      cfg_exp_o = EW'(EMAX);
      cfg_hi_o  = '1;
      cfg_lo_o  = '1;
    end else begin
      step      = (DW+1)'(1) << e;
      tot       = ({1'b0, div_req_i} + step - (DW+1)'(1)) >> e;
      lo_len    = int'(32'(tot)) >> 1;
      hi_len    = int'(32'(tot)) - lo_len;
      cfg_exp_o = EW'(e);
      cfg_hi_o  = (hi_len > 0) ? PW'(hi_len - 1) : '0;
      cfg_lo_o  = (lo_len > 0) ? PW'(lo_len - 1) : '0;
    end
  end
endmodule

// File: rtl/scl_divgen_chk.sv
`timescale 1ns/1ps
module scl_divgen_chk #(
  parameter int PW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          run,
  input logic          scl_low_o,
  input logic          rise_o,
  input logic          fall_o,
  input logic [PW-1:0] cfg_hi_o,
  input logic [PW-1:0] cfg_lo_o
);
  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_o && fall_o));
  p_fall_on_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |-> $rose(scl_low_o));
  p_edge_has_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_low_o) |-> fall_o);
  p_rise_on_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |-> $fell(scl_low_o));
  p_fall_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);
  p_stop_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(en && run) |=> (!scl_low_o && !rise_o && !fall_o));
  p_split_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, cfg_hi_o} >= {1'b0, cfg_lo_o}) && ({1'b0, cfg_hi_o} - {1'b0, cfg_lo_o} <= 1));
endmodule

bind scl_divgen scl_divgen_chk #(.PW(PW)) chk_i (
  .clk(clk), .rst_n(rst_n), .en(en), .run(run),
  .scl_low_o(scl_low_o), .rise_o(rise_o), .fall_o(fall_o),
  .cfg_hi_o(cfg_hi_o), .cfg_lo_o(cfg_lo_o)
);

// File: tb/scl_divgen_tb_top.sv
`timescale 1ns/1ps
module scl_divgen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, run = 1'b0;
  logic [3:0] exp_i = '0;
  logic [3:0] hi_i = '0, lo_i = '0;
  logic [31:0] div_req = '0;
  logic scl_low, rise, fall;
  logic [3:0] c_exp, c_hi, c_lo;
  logic [3:0] c3_exp;
  logic [2:0] c3_hi, c3_lo;
  logic s3_low, s3_rise, s3_fall;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  scl_divgen dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .run(run), .exp_i(exp_i),
    .hi_i(hi_i), .lo_i(lo_i), .div_req_i(div_req),
    .scl_low_o(scl_low), .rise_o(rise), .fall_o(fall),
    .cfg_exp_o(c_exp), .cfg_hi_o(c_hi), .cfg_lo_o(c_lo));

  scl_divgen #(.PW(3)) dut3_i (
    .clk(clk), .rst_n(rst_n), .en(1'b0), .run(1'b0), .exp_i(4'd0),
    .hi_i(3'd0), .lo_i(3'd0), .div_req_i(div_req),
    .scl_low_o(s3_low), .rise_o(s3_rise), .fall_o(s3_fall),
    .cfg_exp_o(c3_exp), .cfg_hi_o(c3_hi), .cfg_lo_o(c3_lo));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void ref_help(input longint d, input int maxt,
                                   output int e, output int h, output int l);
    longint s;
    int hl, ll;
    e = -1;
    for (int k = 15; k >= 0; k--) if (d <= (longint'(maxt) << k)) e = k;
    if (e < 0) begin
      e = 15; h = -1; l = -1;
    end else begin
      s  = (d + (longint'(1) << e) - 1) >> e;
      ll = int'(s / 2);
      hl = int'(s) - ll;
      h  = (hl > 0) ? hl - 1 : 0;
      l  = (ll > 0) ? ll - 1 : 0;
    end
  endfunction

  task automatic help_check(input longint d);
    int e, h, l;
    @(negedge clk) div_req = 32'(d);
    #1;
    ref_help(d, 32, e, h, l);
    if (h < 0) begin
      chk(c_exp == 4'd15 && c_hi == 4'hf && c_lo == 4'hf, "R7", {c_exp, c_hi, c_lo}, 16'hfff);
    end else begin
      chk(c_exp == 4'(e), "R6", c_exp, e);
      chk(c_hi == 4'(h) && c_lo == 4'(l), "R8", {c_hi, c_lo}, {4'(h), 4'(l)});
    end
    ref_help(d, 16, e, h, l);
    if (h < 0) h = 7;
    if (l < 0) l = 7;
    chk(c3_exp == 4'(e) && c3_hi == 3'(h) && c3_lo == 3'(l), "R9",
        {c3_exp, c3_hi, c3_lo}, {4'(e), 3'(h), 3'(l)});
  endtask

  task automatic count_until(input bit want_fall, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!(want_fall ? fall : rise) && n < 5000);
  endtask

  task automatic run_case(input int e, input int h, input int l);
    int n;
    int th = (h + 1) << e;
    int tl = (l + 1) << e;
    @(negedge clk);
    exp_i = 4'(e); hi_i = 4'(h); lo_i = 4'(l); en = 1'b1; run = 1'b1;
    count_until(1'b1, n);
    chk(n == th, "R1 first high", n, th);
    chk(scl_low == 1'b1, "R3 fall aligns", scl_low, 1);
    count_until(1'b0, n);
    chk(n == tl, "R2 low phase", n, tl);
    chk(scl_low == 1'b0 && !fall, "R3 rise aligns", scl_low, 0);
    count_until(1'b1, n);
    chk(n == th, "R1 later high", n, th);
    @(negedge clk);
    if (tl > 1) chk(!fall && scl_low, "R3 one-cycle strobe", fall, 0);
    run = 1'b0;
    @(negedge clk);
    chk(!scl_low && !rise && !fall, "R4 stop in low", {scl_low, rise, fall}, 0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!scl_low && !rise && !fall, "R4 reset state", {scl_low, rise, fall}, 0);
    rst_n = 1'b1;

    run_case(0, 0, 0);
    @(negedge clk) run = 1'b1;
    repeat (6) begin
      @(negedge clk);
      chk(rise || fall, "R5 toggle each clock", {rise, fall}, 1);
    end
    run = 1'b0;

    run_case(2, 3, 1);
    run_case(1, 0, 5);
    run_case(3, 15, 15);
    run_case(4, 1, 0);

    @(negedge clk) exp_i = 4'd1; hi_i = 4'd1; lo_i = 4'd2; run = 1'b1;
    count_until(1'b1, n);
    run = 1'b0;
    @(negedge clk);
    chk(!scl_low && !rise && !fall, "R4 stop at edge", {scl_low, rise, fall}, 0);
    run_case(1, 1, 2);

    @(negedge clk) en = 1'b0; run = 1'b1;
    repeat (40) begin
      @(negedge clk);
      chk(!scl_low && !rise && !fall, "R4 enable low", {scl_low, rise, fall}, 0);
    end
    en = 1'b1; run = 1'b0;

    for (int i = 0; i < 20; i++)
      run_case(int'($urandom_range(0, 3)), int'($urandom_range(0, 15)), int'($urandom_range(0, 15)));

    help_check(0); help_check(1); help_check(2); help_check(3);
    help_check(16); help_check(17); help_check(32); help_check(33);
    help_check(64); help_check(65); help_check(100); help_check(1000);
    help_check(64'd1 << 20); help_check((64'd1 << 20) + 1);
    help_check(64'd1 << 19); help_check((64'd1 << 19) + 1);
    help_check(64'd1 << 21); help_check(64'hffffffff);
    for (int i = 0; i < 60; i++) help_check(longint'($urandom_range(0, 5000)));
    for (int i = 0; i < 30; i++) help_check(longint'($urandom));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule